// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block gives a host processor access to a wide, 16-bit-addressed PHY control-register space through a handful of 32-bit memory-mapped registers. Each internal access is assembled in steps. The host loads a value into a shared data-in register and pulses capture-address, which turns that value into the target address. It can then load write data into the same data-in register and pulse capture-data. Finally it pulses the write trigger or the read trigger.

Each trigger bit reads back as 1 while its operation is pending and clears itself when the operation finishes, so software polls that bit for completion. Read and write operations travel over an internal request/acknowledge link with 16-bit address and data. A built-in register-file model, which acknowledges after a parameterised delay of 1 to 8 cycles, answers that link. A trigger that arrives while an operation is pending is dropped, and a sticky status flag records the overlap.

Top module: `phy_cr_bridge`

## Requirements
- R1: After reset, every host offset listed below reads 0, and internal registers hold their initial values.
- R2: Offset 0x0C (data-in) stores all 32 bits of a host write and reads them back unchanged.
- R3: Writing a 1 in bit 0 of offset 0x14 latches data-in bits 15:0 as the internal address. Bit 0 of 0x14 reads 1 for exactly one cycle after the write, then 0.
- R4: Writing a 1 in bit 0 of offset 0x18 latches data-in bits 15:0 as the pending write data. Bit 0 of 0x18 reads 1 for exactly one cycle after the write.
- R5: Writing a 1 in bit 0 of offset 0x20 stores the latched data at the latched internal address. A later read of that address returns the stored data.
- R6: Writing a 1 in bit 0 of offset 0x1C fetches the internal register at the latched address. Once bit 0 of 0x1C clears, offset 0x10 holds the fetched value in bits 15:0. The first read after an address capture is already correct, and two reads in a row with no new capture return the same value.
- R7: For lane L (L < LANES) and index k (0..15), the internal register sits at address 0x1000 + 0x100·L + k, and its initial value is the address with its upper byte XORed with 0x5A. Any other internal address reads 0 and ignores writes.
- R8: A read or write trigger stays pending for exactly ACK_DELAY+1 cycles after the host write. The internal request stays asserted until it is acknowledged.
- R9: A trigger written while any operation is pending is ignored and sets bit 0 of offset 0x24. That bit stays set until the host writes 1 to it, and writing 0 leaves it set.
- R10: A trigger write with bit 0 equal to 0 starts nothing and changes no latch.
- R11: Host reads from any other offset, including unaligned ones, return 0. Host writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_addr | input | 8 | Host byte offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_addr |

## Verification
The bench sweeps every lane register of a two-lane configuration three ways: reading initial values, reading twice without recapture, and writing then reading back a per-slot pattern. This separates address decoding, read-path staleness and write commit. Addresses that fall just outside the map, such as an index at or above 16 or a lane at or above LANES, show whether the decode is too loose. Overlap sequences send capture and write triggers into a pending read. They then confirm that the address, the data and the target register are unchanged, which keeps "ignored" apart from "queued" and from "executed late".

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  localparam logic [7:0] OFF_DIN  = 8'h0C;
  localparam logic [7:0] OFF_DOUT = 8'h10;
  localparam logic [7:0] OFF_CAPA = 8'h14;
  localparam logic [7:0] OFF_CAPD = 8'h18;
  localparam logic [7:0] OFF_RD   = 8'h1C;
  localparam logic [7:0] OFF_WR   = 8'h20;
  localparam logic [7:0] OFF_STAT = 8'h24;

  // pending vector bit positions
  localparam int PB_CAPA = 0;
  localparam int PB_CAPD = 1;
  localparam int PB_RD   = 2;
  localparam int PB_WR   = 3;
  localparam int NTRIG   = 4;

  localparam logic [15:0] LANE_BASE = 16'h1000;
  localparam int REGS_PER_LANE = 16;

  function automatic logic [7:0] trig_off(input int idx);
    case (idx)
      PB_CAPA: return OFF_CAPA;
      PB_CAPD: return OFF_CAPD;
      PB_RD:   return OFF_RD;
      default: return OFF_WR;
    endcase
  endfunction

  function automatic logic cr_hit(input logic [15:0] a, input int lanes);
    return (a[15:12] == LANE_BASE[15:12]) && (int'(a[11:8]) < lanes) && (a[7:4] == 4'h0);
  endfunction

  function automatic int cr_slot(input logic [15:0] a);
    return int'(a[11:8]) * REGS_PER_LANE + int'(a[3:0]);
  endfunction

  function automatic logic [15:0] cr_addr_of(input int idx);
    return LANE_BASE | 16'((idx / REGS_PER_LANE) << 8) | 16'(idx % REGS_PER_LANE);
  endfunction

  function automatic logic [15:0] cr_init(input logic [15:0] a);
    return a ^ 16'h5A00;
  endfunction

endpackage

// File: rtl/cr_regfile_model.sv
module cr_regfile_model
  import phy_cr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int ACK_DELAY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic [15:0] rdata
);
  localparam int ENTRIES = LANES * REGS_PER_LANE;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = (ACK_DELAY > 1) ? $clog2(ACK_DELAY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_DELAY - 1);

  logic [15:0]   mem [ENTRIES];
  logic [CW-1:0] cnt;
  logic          hit;
  logic [IW-1:0] slot;

  assign hit  = cr_hit(addr, LANES);
  assign slot = IW'(cr_slot(addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      cnt   <= '0;
      rdata <= '0;
      for (int i = 0; i < ENTRIES; i++) mem[i] <= cr_init(cr_addr_of(i));
    end else if (ack) begin
      ack <= 1'b0;
      cnt <= '0;
    end else if (req) begin
      if (cnt == CNT_LAST) begin
        ack   <= 1'b1;
        rdata <= hit ? mem[slot] : 16'h0000;
        if (we && hit) mem[slot] <= wdata;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cr_seq.sv
module cr_seq
  import phy_cr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] start,
  input  logic [15:0]      din,
  input  logic             ack,
  input  logic [15:0]      rdata,
  output logic [NTRIG-1:0] pend,
  output logic             req,
  output logic             we,
  output logic [15:0]      addr_q,
  output logic [15:0]      wdata_q,
  output logic [15:0]      dout
);

  assign req = pend[PB_RD] | pend[PB_WR];
  assign we  = pend[PB_WR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      dout    <= '0;
    end else if (|start) begin
      pend <= start;
    end else begin
      if (pend[PB_CAPA]) begin
        addr_q <= din;
        pend   <= '0;
      end
      if (pend[PB_CAPD]) begin
        wdata_q <= din;
        pend    <= '0;
      end
      if (ack) begin
        if (pend[PB_RD]) dout <= rdata;
        pend <= '0;
      end
    end
  end

endmodule

// File: rtl/cr_host_if.sv
module cr_host_if
  import phy_cr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [7:0]       host_addr,
  input  logic [31:0]      host_wdata,
  input  logic [NTRIG-1:0] pend,
  input  logic [15:0]      dout,
  output logic [31:0]      host_rdata,
  output logic [15:0]      din_lo,
  output logic [NTRIG-1:0] start,
  output logic             overlap
);
  logic [31:0]      din_q;
  logic [NTRIG-1:0] trig_vec;
  logic             busy;
  logic             clr_ovl;

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    assign trig_vec[g] = host_wr && host_wdata[0] && (host_addr == trig_off(g));
  end

  assign busy    = |pend;
  assign start   = busy ? '0 : trig_vec;
  assign clr_ovl = host_wr && host_wdata[0] && (host_addr == OFF_STAT);
  assign din_lo  = din_q[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= '0;
      overlap <= 1'b0;
    end else begin
      if (host_wr && host_addr == OFF_DIN) din_q <= host_wdata;
      if (busy && |trig_vec) overlap <= 1'b1;
      else if (clr_ovl)      overlap <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      OFF_DIN:  host_rdata = din_q;
      OFF_DOUT: host_rdata = {16'h0000, dout};
      OFF_CAPA: host_rdata = {31'd0, pend[PB_CAPA]};
      OFF_CAPD: host_rdata = {31'd0, pend[PB_CAPD]};
      OFF_RD:   host_rdata = {31'd0, pend[PB_RD]};
      OFF_WR:   host_rdata = {31'd0, pend[PB_WR]};
      OFF_STAT: host_rdata = {31'd0, overlap};
      default:  host_rdata = 32'h0000_0000;
    endcase
  end

endmodule

// File: rtl/phy_cr_bridge.sv
module phy_cr_bridge
  import phy_cr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int ACK_DELAY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  logic [NTRIG-1:0] pend;
  logic [NTRIG-1:0] start_vec;
  logic [15:0]      din_lo;
  logic [15:0]      dout;
  logic             overlap;
  logic             cr_req;
  logic             cr_we;
  logic             cr_ack;
  logic [15:0]      cr_addr;
  logic [15:0]      cr_wdata;
  logic [15:0]      cr_rdata;

  cr_host_if u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .pend      (pend),
    .dout      (dout),
    .host_rdata(host_rdata),
    .din_lo    (din_lo),
    .start     (start_vec),
    .overlap   (overlap)
  );

  cr_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_vec),
    .din    (din_lo),
    .ack    (cr_ack),
    .rdata  (cr_rdata),
    .pend   (pend),
    .req    (cr_req),
    .we     (cr_we),
    .addr_q (cr_addr),
    .wdata_q(cr_wdata),
    .dout   (dout)
  );

  cr_regfile_model #(
    .LANES    (LANES),
    .ACK_DELAY(ACK_DELAY)
  ) u_model (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (cr_req),
    .we   (cr_we),
    .addr (cr_addr),
    .wdata(cr_wdata),
    .ack  (cr_ack),
    .rdata(cr_rdata)
  );

endmodule

// File: rtl/cr_bridge_chk.sv
module cr_bridge_chk
  import phy_cr_pkg::*;
#(
  parameter int ACK_DELAY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [7:0]       host_addr,
  input logic             host_bit0,
  input logic [NTRIG-1:0] pend,
  input logic             overlap,
  input logic             cr_req,
  input logic             cr_ack,
  input logic [15:0]      dout
);
  localparam logic [3:0] LIM = 4'(ACK_DELAY);

  logic [3:0] busy_cnt;
  logic       rw_pend;
  logic       trig_wr;

  assign rw_pend = pend[PB_RD] | pend[PB_WR];
  assign trig_wr = host_wr && host_bit0 &&
                   (host_addr == OFF_CAPA || host_addr == OFF_CAPD ||
                    host_addr == OFF_RD   || host_addr == OFF_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (!rw_pend)       busy_cnt <= '0;
    else if (busy_cnt != 4'hF) busy_cnt <= busy_cnt + 1'b1;
  end

  // R8: a read or write never stays pending longer than ACK_DELAY+1 cycles
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rw_pend |-> (busy_cnt <= LIM));

  // R8: request held until acknowledged, and no acknowledge without request
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && !cr_ack) |=> cr_req);
  p_ack_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_ack |-> cr_req);

  // R3: capture-address pending lasts a single cycle
  p_capa_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend[PB_CAPA] |=> !pend[PB_CAPA]);

  // R4: capture-data pending lasts a single cycle
  p_capd_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend[PB_CAPD] |=> !pend[PB_CAPD]);

  // R9: at most one operation pending, and overlap recorded
  p_single_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend));
  p_overlap_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && |pend) |=> overlap);

  // R6: read result only changes on an acknowledge
  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_ack |=> $stable(dout));

endmodule

bind phy_cr_bridge cr_bridge_chk #(.ACK_DELAY(ACK_DELAY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_wr  (host_wr),
  .host_addr(host_addr),
  .host_bit0(host_wdata[0]),
  .pend     (pend),
  .overlap  (overlap),
  .cr_req   (cr_req),
  .cr_ack   (cr_ack),
  .dout     (dout)
);

// File: tb/sim_phy_cr_bridge.sv
`timescale 1ns/1ps
module sim_phy_cr_bridge;
  localparam int LANES = 2;
  localparam int DLY   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  phy_cr_bridge #(.LANES(LANES), .ACK_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] init_of(input logic [15:0] a);
    return {a[15:8] ^ 8'h5A, a[7:0]};
  endfunction

  function automatic logic [15:0] pat_of(input int lane, input int k);
    return 16'((k * 16'h0313) ^ (lane * 16'h8421) ^ 16'hC0DE);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] v);
    host_wr = 1'b0; host_addr = a;
    #0.5;
    v = host_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic cap(input logic [7:0] off, input logic [15:0] v);
    hw(8'h0C, {16'h0, v});
    hw(off, 32'h1);
    idle();
  endtask

  // start a trigger and poll; returns cycles the bit read as 1
  task automatic run_op(input logic [7:0] off, output int n);
    logic [31:0] v;
    hw(off, 32'h1);
    n = 0;
    hr(off, v);
    while (v[0] && n < 50) begin
      n++;
      idle();
      hr(off, v);
    end
  endtask

  task automatic cr_rd(input logic [15:0] a, output logic [15:0] d);
    int n;
    logic [31:0] v;
    cap(8'h14, a);
    run_op(8'h1C, n);
    chk("R8 read pending cycles", n, DLY + 1);
    hr(8'h10, v);
    d = v[15:0];
  endtask

  task automatic cr_wr(input logic [15:0] a, input logic [15:0] d);
    int n;
    cap(8'h14, a);
    cap(8'h18, d);
    run_op(8'h20, n);
    chk("R8 write pending cycles", n, DLY + 1);
  endtask

  task automatic check_all_zero(input string tag);
    logic [31:0] v;
    hr(8'h0C, v); chk({tag, " din"}, v, 0);
    hr(8'h10, v); chk({tag, " dout"}, v, 0);
    hr(8'h14, v); chk({tag, " capa"}, v, 0);
    hr(8'h18, v); chk({tag, " capd"}, v, 0);
    hr(8'h1C, v); chk({tag, " rd"}, v, 0);
    hr(8'h20, v); chk({tag, " wr"}, v, 0);
    hr(8'h24, v); chk({tag, " stat"}, v, 0);
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] d, d2, a;
    int n;

    repeat (3) @(negedge clk);
    check_all_zero("R1 reset");
    rst_n = 1'b1;
    idle();
    check_all_zero("R1 after release");

    // R2 full-width data-in
    hw(8'h0C, 32'hDEAD_BEEF);
    hr(8'h0C, v); chk("R2 din readback", v, 32'hDEAD_BEEF);
    hw(8'h0C, 32'h1234_5678);
    hr(8'h0C, v); chk("R2 din overwrite", v, 32'h1234_5678);

    // R3 / R4 one-cycle pending bits
    hw(8'h0C, 32'h0000_1002);
    hw(8'h14, 32'h1);
    hr(8'h14, v); chk("R3 capa pending", v, 1);
    idle();
    hr(8'h14, v); chk("R3 capa cleared", v, 0);
    hw(8'h18, 32'h1);
    hr(8'h18, v); chk("R4 capd pending", v, 1);
    idle();
    hr(8'h18, v); chk("R4 capd cleared", v, 0);

    // R6 / R7 initial-value sweep with back-to-back reads
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < 16; k++) begin
        a = 16'h1000 + 16'(l * 16'h100) + 16'(k);
        cr_rd(a, d);
        chk("R7 initial value", {16'h0, d}, {16'h0, init_of(a)});
        run_op(8'h1C, n);
        hr(8'h10, v);
        chk("R6 repeat read", v, {16'h0, d});
      end
    end

    // R7 addresses outside the map read 0
    cr_rd(16'h0000, d); chk("R7 unmapped 0000", {16'h0, d}, 0);
    cr_rd(16'h1010, d); chk("R7 index >= 16", {16'h0, d}, 0);
    cr_rd(16'h1000 + 16'(LANES * 16'h100) + 16'h6, d); chk("R7 lane >= LANES", {16'h0, d}, 0);
    cr_rd(16'h2006, d); chk("R7 wrong base", {16'h0, d}, 0);

    // R5 write sweep then readback
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < 16; k++)
        cr_wr(16'h1000 + 16'(l * 16'h100) + 16'(k), pat_of(l, k));
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < 16; k++) begin
        cr_rd(16'h1000 + 16'(l * 16'h100) + 16'(k), d);
        chk("R5 write readback", {16'h0, d}, {16'h0, pat_of(l, k)});
      end
    end
    cr_wr(16'h1010, 16'hFFFF);
    cr_rd(16'h1010, d); chk("R7 unmapped write dropped", {16'h0, d}, 0);
    cr_rd(16'h1000, d); chk("R7 alias untouched", {16'h0, d}, {16'h0, pat_of(0, 0)});

    // R9 overlap: triggers during a pending read are ignored
    cr_wr(16'h1003, 16'h0AA5);
    cap(8'h18, 16'hBEEF);
    cap(8'h14, 16'h1003);
    hw(8'h1C, 32'h1);
    hw(8'h0C, 32'h0000_1100);
    hw(8'h14, 32'h1);
    hw(8'h20, 32'h1);
    repeat (DLY + 2) idle();
    hr(8'h24, v); chk("R9 overlap flag set", v, 1);
    hr(8'h20, v); chk("R9 write not queued", v, 0);
    hr(8'h10, v); chk("R9 read result", v, 32'h0AA5);
    run_op(8'h1C, n);
    hr(8'h10, v); chk("R9 address kept", v, 32'h0AA5);
    hw(8'h24, 32'h0);
    hr(8'h24, v); chk("R9 write 0 keeps flag", v, 1);
    hw(8'h24, 32'h1);
    hr(8'h24, v); chk("R9 flag cleared", v, 0);
    cr_rd(16'h1100, d); chk("R9 no stray write", {16'h0, d}, {16'h0, pat_of(1, 0)});

    // R10 trigger writes with bit 0 clear
    cap(8'h14, 16'h1105);
    hw(8'h0C, 32'h0000_1001);
    hw(8'h14, 32'h0);
    hr(8'h14, v); chk("R10 capa zero no pending", v, 0);
    hw(8'h1C, 32'hFFFF_FFFE);
    hr(8'h1C, v); chk("R10 read zero no pending", v, 0);
    hw(8'h20, 32'h0);
    hr(8'h20, v); chk("R10 write zero no pending", v, 0);
    run_op(8'h1C, n);
    hr(8'h10, v); chk("R10 address unchanged", v, {16'h0, pat_of(1, 5)});

    // R11 other offsets
    hw(8'h0C, 32'hCAFE_F00D);
    hw(8'h28, 32'hFFFF_FFFF);
    hw(8'h0D, 32'hFFFF_FFFF);
    hw(8'h00, 32'hFFFF_FFFF);
    hr(8'h28, v); chk("R11 read 0x28", v, 0);
    hr(8'h0D, v); chk("R11 read 0x0D", v, 0);
    hr(8'h00, v); chk("R11 read 0x00", v, 0);
    hr(8'hFC, v); chk("R11 read 0xFC", v, 0);
    hr(8'h0C, v); chk("R11 din untouched", v, 32'hCAFE_F00D);
    hr(8'h24, v); chk("R11 stat untouched", v, 0);

    // R1 reset in mid-run restores everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) idle();
    check_all_zero("R1 second reset");
    rst_n = 1'b1;
    idle();
    cr_rd(16'h1105, d); chk("R1 register reinit", {16'h0, d}, {16'h0, init_of(16'h1105)});
    cr_rd(16'h100F, d2); chk("R1 register reinit lane0", {16'h0, d2}, {16'h0, init_of(16'h100F)});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule